// File: doc/BRIEF.md
# Parallel thread spawn dispatcher

The dispatcher starts a region of short parallel threads and hands their IDs out, at run time, to a fixed pool of thread processing units. A master issues a spawn command carrying a low and a high thread ID. The region then holds the threads `low` through `high-1`. No ID is bound to a unit in advance. Whenever a unit is idle it raises a request. In the same cycle it receives either the next unissued ID or a "no more work" reply. The shared ID register advances by the number of grants made in that cycle, in the manner of a fetch-and-increment. Load therefore balances itself across the units.

Each thread ends with an implicit join: the unit that ran it pulses its join line once. The block counts the threads that are still outstanding. When every ID has been issued and every issued thread has joined, the block raises a one-cycle completion pulse to the master. While a region is active, new spawn commands are refused.

The controller is a three-state machine:
- `ST_IDLE`: ready for a spawn command. The transition *accept* (`spawn_valid` while ready) latches the bounds and moves to `ST_RUN`.
- `ST_RUN`: serves requests and counts joins. The transition *drained* (all IDs issued and the outstanding count at zero) moves to `ST_FINISH`.
- `ST_FINISH`: drives the completion pulse. The transition *retire* returns to `ST_IDLE` unconditionally one cycle later.

Top module: `spawn_dispatcher`

## Requirements
- R1: A spawn with bounds `lo` and `hi` (`hi >= lo`) issues exactly `hi-lo` threads, with the IDs `lo` through `hi-1`. Each ID is issued exactly once.
- R2: When several units request in the same cycle, each requester receives a distinct ID in that same cycle. The IDs are consecutive and follow unit index order: a lower index gets a lower ID. The ID for unit `i` is on `grant_id[i*ID_W +: ID_W]`.
- R3: A request receives `grant_none` and no `grant` in the same cycle when either of these holds:
  - the range is exhausted;
  - the block is not in `ST_RUN`.
- R4: `spawn_ready` is low from the cycle after a spawn is accepted until the completion pulse has ended. A `spawn_valid` presented while not ready has no effect on the IDs issued.
- R5: `done_pulse` is high for exactly one cycle. It appears in the cycle after the one in which all IDs are issued and the outstanding count is zero.
- R6: A spawn with `lo == hi` issues no threads. Its pulse appears in the second cycle after acceptance.
- R7: Each `join_i` pulse retires one outstanding thread. The pulse waits for the last join, however late that join arrives.
- R8: After reset the block is idle: `spawn_ready` is 1, and `done_pulse` and all grants are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_valid | input | 1 | Spawn command present |
| spawn_lo | input | ID_W | First thread ID of the region |
| spawn_hi | input | ID_W | One past the last thread ID |
| spawn_ready | output | 1 | Block can accept a spawn |
| req | input | N_UNITS | Per-unit request for a thread |
| grant | output | N_UNITS | Per-unit ID granted this cycle |
| grant_none | output | N_UNITS | Per-unit "no more work" reply |
| grant_id | output | N_UNITS*ID_W | Per-unit granted ID, unit i at bits i*ID_W |
| join_i | input | N_UNITS | Per-unit thread-end pulse |
| done_pulse | output | 1 | One-cycle region-complete pulse |

## Verification
Two functions can fall in the same cycle:
- several units claiming IDs at once;
- the final join arriving together with the last grant or with a "no more work" reply.

The bench sweeps many small regions under rotating request and join-latency patterns. These patterns regularly line up multiple requests in one cycle. They also produce joins in the same cycle as the grants that exhaust the range. The bench computes the expected ID for each unit arithmetically from its priority position and the running next-ID. It judges the completion pulse by the exact cycle in which it appears.

// File: rtl/sd_pkg.sv
package sd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } sd_state_e;
endpackage

// File: rtl/sd_id_alloc.sv
module sd_id_alloc #(
    parameter int N_UNITS = 4,
    parameter int ID_W    = 8,
    localparam int CNT_W  = $clog2(N_UNITS + 1)
) (
    input  logic                      active,
    input  logic [ID_W-1:0]           next_id,
    input  logic [ID_W-1:0]           hi_id,
    input  logic [N_UNITS-1:0]        req,
    output logic [N_UNITS-1:0]        grant,
    output logic [N_UNITS-1:0]        none,
    output logic [N_UNITS*ID_W-1:0]   ids,
    output logic [CNT_W-1:0]          grant_cnt
);
    logic [ID_W:0] remaining;
    logic [ID_W:0] pos;

    assign remaining = {1'b0, hi_id} - {1'b0, next_id};

    always_comb begin
        grant     = '0;
        none      = '0;
        ids       = '0;
        grant_cnt = '0;
        pos       = '0;
        for (int i = 0; i < N_UNITS; i++) begin
            if (req[i]) begin
                if (active && (pos < remaining)) begin
                    grant[i]              = 1'b1;
                    ids[i*ID_W +: ID_W]   = next_id + pos[ID_W-1:0];
                    grant_cnt             = grant_cnt + 1'b1;
                end else begin
                    none[i] = 1'b1;
                end
                pos = pos + 1'b1;
            end
        end
    end

    always_comb begin
        assert ((grant & none) == '0); // R3
        assert ((grant | none) == req); // R2
    end
endmodule

// File: rtl/sd_thread_count.sv
module sd_thread_count #(
    parameter int N_UNITS = 4,
    parameter int ID_W    = 8,
    localparam int CNT_W  = $clog2(N_UNITS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic [CNT_W-1:0]   add_cnt,
    input  logic [N_UNITS-1:0] join_vec,
    output logic [ID_W:0]      outstanding,
    output logic               zero
);
    logic [CNT_W-1:0] join_cnt;

    always_comb begin
        join_cnt = '0;
        for (int i = 0; i < N_UNITS; i++)
            join_cnt = join_cnt + CNT_W'(join_vec[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            outstanding <= '0;
        else
            outstanding <= outstanding + (ID_W+1)'(add_cnt) - (ID_W+1)'(join_cnt);
    end

    assign zero = (outstanding == '0);

    AST_JOIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> ((ID_W+1)'(join_cnt) <= outstanding + (ID_W+1)'(add_cnt))); // R7
endmodule

// File: rtl/spawn_dispatcher.sv
module spawn_dispatcher #(
    parameter int N_UNITS = 4,
    parameter int ID_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      spawn_valid,
    input  logic [ID_W-1:0]           spawn_lo,
    input  logic [ID_W-1:0]           spawn_hi,
    output logic                      spawn_ready,
    input  logic [N_UNITS-1:0]        req,
    output logic [N_UNITS-1:0]        grant,
    output logic [N_UNITS-1:0]        grant_none,
    output logic [N_UNITS*ID_W-1:0]   grant_id,
    input  logic [N_UNITS-1:0]        join_i,
    output logic                      done_pulse
);
    import sd_pkg::*;
    localparam int CNT_W = $clog2(N_UNITS + 1);

    sd_state_e        state_q, state_d;
    logic [ID_W-1:0]  next_q, hi_q;
    logic [CNT_W-1:0] grant_cnt;
    logic [ID_W:0]    outstanding;
    logic             cnt_zero, accept, drained;

    assign accept  = (state_q == ST_IDLE) && spawn_valid;
    assign drained = (next_q == hi_q) && cnt_zero;

    sd_id_alloc #(.N_UNITS(N_UNITS), .ID_W(ID_W)) u_alloc (
        .active    (state_q == ST_RUN),
        .next_id   (next_q),
        .hi_id     (hi_q),
        .req       (req),
        .grant     (grant),
        .none      (grant_none),
        .ids       (grant_id),
        .grant_cnt (grant_cnt)
    );

    sd_thread_count #(.N_UNITS(N_UNITS), .ID_W(ID_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .add_cnt     (grant_cnt),
        .join_vec    (join_i),
        .outstanding (outstanding),
        .zero        (cnt_zero)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)  state_d = ST_RUN;
            ST_RUN:    if (drained) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            next_q  <= '0;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                next_q <= spawn_lo;
                hi_q   <= spawn_hi;
            end else if (state_q == ST_RUN) begin
                next_q <= next_q + ID_W'(grant_cnt);
            end
        end
    end

    always_comb begin
        spawn_ready = (state_q == ST_IDLE);
        done_pulse  = (state_q == ST_FINISH);
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R5
    AST_PULSE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_pulse) |-> $past(next_q == hi_q && outstanding == '0)); // R5
    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (spawn_valid && spawn_ready) |=> !spawn_ready); // R4
    AST_EXHAUSTED_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (next_q == hi_q) |-> (grant == '0)); // R3
    AST_ID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && state_d == ST_RUN) |=>
            (next_q == $past(next_q) + ID_W'($countones($past(grant))))); // R1
endmodule

// File: tb/tb_spawn_dispatcher.sv
module tb_spawn_dispatcher;
    localparam int N = 4;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           spawn_valid;
    logic [W-1:0]   spawn_lo, spawn_hi;
    logic           spawn_ready;
    logic [N-1:0]   req, grant, grant_none, join_i;
    logic [N*W-1:0] grant_id;
    logic           done_pulse;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    spawn_dispatcher #(.N_UNITS(N), .ID_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .spawn_valid(spawn_valid), .spawn_lo(spawn_lo),
        .spawn_hi(spawn_hi), .spawn_ready(spawn_ready), .req(req), .grant(grant),
        .grant_none(grant_none), .grant_id(grant_id), .join_i(join_i),
        .done_pulse(done_pulse)
    );

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic run_region(input int lo, input int hi, input int m);
        int  exp_next, cyc, issued, k;
        int  cd[N];
        bit  busy[N];
        bit  oow[N];
        bit  seen[256];
        for (int i = 0; i < N; i++) begin busy[i] = 0; oow[i] = 0; cd[i] = 0; end
        for (int i = 0; i < 256; i++) seen[i] = 0;
        @(negedge clk);
        check(spawn_ready == 1'b1, "R4 ready before spawn", spawn_ready, 1);
        spawn_valid = 1'b1; spawn_lo = W'(lo); spawn_hi = W'(hi);
        @(posedge clk); #1 spawn_valid = 1'b0;
        @(negedge clk);
        exp_next = lo; cyc = 0; issued = 0;
        while (!(exp_next == hi && !busy[0] && !busy[1] && !busy[2] && !busy[3])) begin
            check(done_pulse == 1'b0, "R5 no early pulse", done_pulse, 0);
            check(spawn_ready == 1'b0, "R4 busy refuse", spawn_ready, 0);
            req = '0; join_i = '0;
            for (int i = 0; i < N; i++) begin
                if (busy[i]) begin
                    if (cd[i] == 0) begin join_i[i] = 1'b1; busy[i] = 0; end
                    else cd[i]--;
                end else if (!oow[i] && ((cyc + i + m) % 3 != 0)) begin
                    req[i] = 1'b1;
                end
            end
            if (cyc % 4 == 1) begin
                spawn_valid = 1'b1; spawn_lo = 8'd200; spawn_hi = 8'd201;
            end
            #1;
            k = 0;
            for (int i = 0; i < N; i++) begin
                if (req[i]) begin
                    if (exp_next < hi) begin
                        check(grant[i] && !grant_none[i], "R2 grant", grant[i], 1);
                        check(int'(grant_id[i*W +: W]) == exp_next, "R2 id order",
                              grant_id[i*W +: W], exp_next);
                        check(!seen[exp_next], "R1 unique id", 1, 0);
                        seen[exp_next] = 1; issued++;
                        exp_next++; k++;
                        busy[i] = 1; cd[i] = (i * m + cyc) % 4;
                    end else begin
                        check(grant_none[i] && !grant[i], "R3 no more work", grant_none[i], 1);
                        oow[i] = 1;
                    end
                end else begin
                    check(!grant[i] && !grant_none[i], "R3 silent when idle",
                          grant[i] | grant_none[i], 0);
                end
            end
            @(posedge clk); #1;
            req = '0; join_i = '0; spawn_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        check(issued == hi - lo, "R1 thread count", issued, hi - lo);
        check(done_pulse == 1'b0, "R7 pulse waits one cycle", done_pulse, 0);
        @(negedge clk);
        if (lo == hi)
            check(done_pulse == 1'b1, "R6 empty region pulse", done_pulse, 1);
        else
            check(done_pulse == 1'b1, "R5 pulse after drain", done_pulse, 1);
        @(negedge clk);
        check(done_pulse == 1'b0, "R5 pulse one cycle", done_pulse, 0);
        check(spawn_ready == 1'b1, "R4 ready after pulse", spawn_ready, 1);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; spawn_valid = 1'b0; spawn_lo = '0; spawn_hi = '0;
        req = '0; join_i = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(spawn_ready == 1'b1, "R8 reset ready", spawn_ready, 1);
        check(done_pulse == 1'b0, "R8 reset pulse", done_pulse, 0);
        check(grant == '0, "R8 reset grant", grant, 0);
        req = '1; #1;
        check(grant_none == '1 && grant == '0, "R3 idle reply", grant_none, 15);
        @(negedge clk); req = '0;
        for (int lo = 0; lo < 8; lo += 3)
            for (int d = 0; d < 10; d++)
                for (int m = 0; m < 3; m++)
                    run_region(lo, lo + d, m);
        run_region(247, 255, 1);
        run_region(255, 255, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule